// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Tracker

This block sits between a core's memory stage and a pipelined request/response data port. That port carries an exclusive attribute on requests and returns an exclusive-okay flag with each response. It holds one reservation bit. From that bit it decides whether a store-conditional reaches the bus or is dropped locally. It also works out the value written back to the destination register and converts bus error responses into access-fault causes.

Each memory operation is offered in an address phase, which is accepted when `hready` is high. Its result appears in the data phase that follows, in the cycle `hready` is high again. A store-conditional found without a reservation takes no bus transfer; it still occupies one local data-phase slot so that results stay in order.

Top module: `rsv_unit`

## Requirements
- R1: After the asynchronous active-low reset the reservation is clear, `htrans` is IDLE (2'b00) and no result or exception is output, so the first store-conditional is suppressed.
- R2: A load-reserved (op 3) completing without error writes `hrdata` to rd. It sets the reservation exactly when `hexokay` is high, and is requested as NONSEQ (2'b10) with `hexcl` high and `hwrite` low.
- R3: A store-conditional (op 4) with the reservation set is issued as NONSEQ with `hexcl` and `hwrite` high. If it completes with `hexokay` high and no error, it writes 0 to rd and clears the reservation.
- R4: A store-conditional that completes without error and without `hexokay` writes 1 to rd and clears the reservation.
- R5: A store-conditional offered while the reservation is clear drives `htrans` IDLE, raises no exception and writes 0 to rd in the following cycle.
- R6: A load-reserved that completes with `hresp_err` raises cause 5 and writes nothing to rd. It clears the reservation even when `hexokay` is also high.
- R7: A store-conditional that completes with `hresp_err` raises cause 7, leaves rd unwritten and clears the reservation, so the next store-conditional is suppressed and writes 0.
- R8: While `hready` is low in a data phase, no result or exception is output and the reservation keeps its value; the outcome appears in the first cycle `hready` is high.
- R9: An accepted atomic operation (op 5) clears the reservation. It is requested as a non-exclusive read, writes `hrdata` to rd, and raises cause 7 on error.
- R10: Ordinary loads (op 1) and stores (op 2) are requested as NONSEQ with `hexcl` low. A load writes `hrdata` to rd, and a load error raises cause 5. A store writes nothing, and a store error raises cause 7.
- R11: With `flush` high, the offered operation is not requested, produces no result and leaves the reservation unchanged, including a flushed atomic operation.
- R12: A store-conditional offered in the same cycle that a load-reserved completes sees the reservation value that completion produces.
- R13: `exc_valid` is a single-cycle pulse in the completion cycle, and `rd_we` is low in any cycle with `exc_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_kind | input | 3 | Offered operation: 0 none, 1 load, 2 store, 3 load-reserved, 4 store-conditional, 5 atomic |
| op_addr | input | AW | Operation address |
| flush | input | 1 | Kill the offered operation |
| hready | input | 1 | Bus ready: accepts address phase, completes data phase |
| hresp_err | input | 1 | Data-phase error response |
| hexokay | input | 1 | Data-phase exclusive-okay response |
| hrdata | input | DW | Data-phase read data |
| htrans | output | 2 | Transfer type: 2'b00 IDLE, 2'b10 NONSEQ |
| hexcl | output | 1 | Exclusive attribute of the request |
| hwrite | output | 1 | Write request |
| haddr | output | AW | Request address |
| rd_we | output | 1 | Destination register write enable |
| rd_wdata | output | DW | Destination register write value |
| exc_valid | output | 1 | Access-fault pulse |
| exc_cause | output | CW | Fault cause: 5 load, 7 store/atomic |

## Verification
The request outputs (`htrans`, `hexcl`) depend on the offered operation in the same cycle, so they are sampled in the offering cycle itself. A result or exception is due in the first cycle after the address phase in which `hready` is high. For a suppressed store-conditional, that is simply the next cycle. The driver pushes each expected outcome before that cycle. The monitor pops an item whenever `rd_we` or `exc_valid` is high, and the driver then confirms the queue is empty one cycle later, so a result that is late, early or repeated shows up as a failure. For the back-to-back case, the store-conditional's request is checked in the very cycle the load-reserved completes.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_LOAD  = 3'd1,
        OP_STORE = 3'd2,
        OP_LR    = 3'd3,
        OP_SC    = 3'd4,
        OP_AMO   = 3'd5
    } op_e;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_NONSEQ = 2'b10;

    localparam int CAUSE_LOAD_FAULT  = 5;
    localparam int CAUSE_STORE_FAULT = 7;

    // One outstanding data phase: real transfer or locally dropped SC
    typedef struct packed {
        logic       valid;
        logic       local_sc;
        logic [2:0] kind;
    } dph_t;

endpackage

// File: rtl/rsv_issue.sv
module rsv_issue
    import rsv_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [2:0]    op_kind,
    input  logic [AW-1:0] op_addr,
    input  logic          flush,
    input  logic          hready,
    input  logic          rsv_fwd,
    output logic [1:0]    htrans,
    output logic          hexcl,
    output logic          hwrite,
    output logic [AW-1:0] haddr,
    output logic          acc_valid,
    output logic          acc_local,
    output logic [2:0]    acc_kind,
    output logic          amo_clear
);

    logic is_mem;
    logic is_excl;
    logic is_wr;
    logic live;
    logic suppress;
    logic on_bus;

    always_comb begin
        is_mem  = 1'b0;
        is_excl = 1'b0;
        is_wr   = 1'b0;
        case (op_kind)
            OP_LOAD:  is_mem = 1'b1;
            OP_STORE: begin is_mem = 1'b1; is_wr = 1'b1; end
            OP_LR:    begin is_mem = 1'b1; is_excl = 1'b1; end
            OP_SC:    begin is_mem = 1'b1; is_excl = 1'b1; is_wr = 1'b1; end
            OP_AMO:   is_mem = 1'b1;
            default:  is_mem = 1'b0;
        endcase

        live     = is_mem && !flush;
        // SC without reservation never reaches the bus
        suppress = (op_kind == OP_SC) && !rsv_fwd;
        on_bus   = live && !suppress;

        htrans    = on_bus ? TR_NONSEQ : TR_IDLE;
        hexcl     = on_bus && is_excl;
        hwrite    = on_bus && is_wr;
        haddr     = on_bus ? op_addr : '0;

        acc_valid = live && hready;
        acc_local = suppress;
        acc_kind  = op_kind;
        amo_clear = live && hready && (op_kind == OP_AMO);
    end

endmodule

// File: rtl/rsv_dphase.sv
module rsv_dphase
    import rsv_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hready,
    input  logic          hresp_err,
    input  logic          hexokay,
    input  logic [DW-1:0] hrdata,
    input  logic          acc_valid,
    input  logic          acc_local,
    input  logic [2:0]    acc_kind,
    output logic          dph_valid,
    output logic          dph_local,
    output logic [2:0]    dph_kind,
    output logic          rd_we,
    output logic [DW-1:0] rd_wdata,
    output logic          exc_valid,
    output logic [CW-1:0] exc_cause,
    output logic          lr_done,
    output logic          sc_done,
    output logic          excl_grant
);

    dph_t st_q;
    dph_t st_d;
    logic done;

    always_comb begin
        st_d = st_q;
        if (hready) begin
            st_d.valid    = acc_valid;
            st_d.local_sc = acc_valid && acc_local;
            st_d.kind     = acc_valid ? acc_kind : OP_NONE;
        end

        done      = st_q.valid && hready;
        rd_we     = 1'b0;
        rd_wdata  = '0;
        exc_valid = 1'b0;
        exc_cause = '0;

        if (done) begin
            if (st_q.local_sc) begin
                rd_we = 1'b1;
            end else if (hresp_err) begin
                exc_valid = 1'b1;
                if (st_q.kind == OP_LOAD || st_q.kind == OP_LR)
                    exc_cause = CW'(CAUSE_LOAD_FAULT);
                else
                    exc_cause = CW'(CAUSE_STORE_FAULT);
            end else begin
                case (st_q.kind)
                    OP_LOAD, OP_LR, OP_AMO: begin
                        rd_we    = 1'b1;
                        rd_wdata = hrdata;
                    end
                    OP_SC: begin
                        rd_we    = 1'b1;
                        rd_wdata = hexokay ? '0 : DW'(1);
                    end
                    default: rd_we = 1'b0;
                endcase
            end
        end

        lr_done    = done && !st_q.local_sc && (st_q.kind == OP_LR);
        sc_done    = done && (st_q.kind == OP_SC);
        excl_grant = hexokay && !hresp_err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dph_valid = st_q.valid;
    assign dph_local = st_q.local_sc;
    assign dph_kind  = st_q.kind;

endmodule

// File: rtl/rsv_monitor.sv
module rsv_monitor (
    input  logic clk,
    input  logic rst_n,
    input  logic lr_done,
    input  logic sc_done,
    input  logic excl_grant,
    input  logic amo_clear,
    output logic rsv_q,
    output logic rsv_fwd
);

    logic rsv_d;

    always_comb begin
        // Value after this cycle's data-phase completion, seen by issue
        if (sc_done)      rsv_fwd = 1'b0;
        else if (lr_done) rsv_fwd = excl_grant;
        else              rsv_fwd = rsv_q;
        rsv_d = amo_clear ? 1'b0 : rsv_fwd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsv_q <= 1'b0;
        else        rsv_q <= rsv_d;
    end

endmodule

// File: rtl/rsv_unit.sv
module rsv_unit
    import rsv_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    op_kind,
    input  logic [AW-1:0] op_addr,
    input  logic          flush,
    input  logic          hready,
    input  logic          hresp_err,
    input  logic          hexokay,
    input  logic [DW-1:0] hrdata,
    output logic [1:0]    htrans,
    output logic          hexcl,
    output logic          hwrite,
    output logic [AW-1:0] haddr,
    output logic          rd_we,
    output logic [DW-1:0] rd_wdata,
    output logic          exc_valid,
    output logic [CW-1:0] exc_cause
);

    logic       rsv_q;
    logic       rsv_fwd;
    logic       acc_valid;
    logic       acc_local;
    logic [2:0] acc_kind;
    logic       amo_clear;
    logic       dph_valid;
    logic       dph_local;
    logic [2:0] dph_kind;
    logic       lr_done;
    logic       sc_done;
    logic       excl_grant;

    rsv_issue #(.AW(AW)) u_issue (
        .op_kind   (op_kind),
        .op_addr   (op_addr),
        .flush     (flush),
        .hready    (hready),
        .rsv_fwd   (rsv_fwd),
        .htrans    (htrans),
        .hexcl     (hexcl),
        .hwrite    (hwrite),
        .haddr     (haddr),
        .acc_valid (acc_valid),
        .acc_local (acc_local),
        .acc_kind  (acc_kind),
        .amo_clear (amo_clear)
    );

    rsv_dphase #(.DW(DW), .CW(CW)) u_dphase (
        .clk        (clk),
        .rst_n      (rst_n),
        .hready     (hready),
        .hresp_err  (hresp_err),
        .hexokay    (hexokay),
        .hrdata     (hrdata),
        .acc_valid  (acc_valid),
        .acc_local  (acc_local),
        .acc_kind   (acc_kind),
        .dph_valid  (dph_valid),
        .dph_local  (dph_local),
        .dph_kind   (dph_kind),
        .rd_we      (rd_we),
        .rd_wdata   (rd_wdata),
        .exc_valid  (exc_valid),
        .exc_cause  (exc_cause),
        .lr_done    (lr_done),
        .sc_done    (sc_done),
        .excl_grant (excl_grant)
    );

    rsv_monitor u_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .lr_done    (lr_done),
        .sc_done    (sc_done),
        .excl_grant (excl_grant),
        .amo_clear  (amo_clear),
        .rsv_q      (rsv_q),
        .rsv_fwd    (rsv_fwd)
    );

endmodule

// File: rtl/rsv_unit_chk.sv
module rsv_unit_chk
    import rsv_pkg::*;
#(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    op_kind,
    input logic          flush,
    input logic          hready,
    input logic          hresp_err,
    input logic [1:0]    htrans,
    input logic          hexcl,
    input logic          rd_we,
    input logic          exc_valid,
    input logic [CW-1:0] exc_cause,
    input logic          rsv_q,
    input logic          rsv_fwd,
    input logic          dph_valid,
    input logic          dph_local,
    input logic [2:0]    dph_kind
);

    // R13
    exc_squashes_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !rd_we);

    // R8
    stall_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hready |-> (!rd_we && !exc_valid));

    // R11
    flush_no_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (htrans == TR_IDLE));

    // R2
    excl_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_NONSEQ && (op_kind == OP_LR || op_kind == OP_SC)) |-> hexcl);

    // R10
    plain_attr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (htrans == TR_NONSEQ && (op_kind == OP_LOAD || op_kind == OP_STORE)) |-> !hexcl);

    // R5
    sc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OP_SC && !rsv_fwd) |-> (htrans == TR_IDLE));

    // R9
    amo_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_kind == OP_AMO && hready && !flush) |=> !rsv_q);

    // R6
    lr_fault_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dph_valid && !dph_local && dph_kind == OP_LR && hready && hresp_err) |=> !rsv_q);

    // R7
    sc_done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dph_valid && dph_kind == OP_SC && hready) |=> !rsv_q);

    // R7
    sc_fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dph_valid && !dph_local && dph_kind == OP_SC && hready && hresp_err)
        |-> (exc_valid && exc_cause == CW'(CAUSE_STORE_FAULT) && !rd_we));

endmodule

bind rsv_unit rsv_unit_chk #(.CW(CW)) chk (.*);

// File: tb/rsv_unit_test.sv
module rsv_unit_test;
    import rsv_pkg::*;

    localparam int CLK_NS = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_kind = 3'd0;
    logic [31:0] op_addr = '0;
    logic        flush = 1'b0;
    logic        hready = 1'b1;
    logic        hresp_err = 1'b0;
    logic        hexokay = 1'b0;
    logic [31:0] hrdata = '0;
    logic [1:0]  htrans;
    logic        hexcl;
    logic        hwrite;
    logic [31:0] haddr;
    logic        rd_we;
    logic [31:0] rd_wdata;
    logic        exc_valid;
    logic [3:0]  exc_cause;

    typedef struct {
        bit          exc;
        logic [3:0]  cause;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t sbq[$];
    int   checks = 0;
    int   fails  = 0;

    always #(CLK_NS/2) clk = ~clk;

    rsv_unit uut (
        .clk(clk), .rst_n(rst_n), .op_kind(op_kind), .op_addr(op_addr),
        .flush(flush), .hready(hready), .hresp_err(hresp_err),
        .hexokay(hexokay), .hrdata(hrdata), .htrans(htrans), .hexcl(hexcl),
        .hwrite(hwrite), .haddr(haddr), .rd_we(rd_we), .rd_wdata(rd_wdata),
        .exc_valid(exc_valid), .exc_cause(exc_cause)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input bit exc, input logic [3:0] cause,
                        input logic [31:0] val, input string req);
        exp_t e;
        e.exc = exc; e.cause = cause; e.val = val; e.req = req;
        sbq.push_back(e);
    endtask

    // Monitor: pops one expected item per produced result
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && (rd_we || exc_valid)) begin
                exp_t e;
                if (sbq.size() == 0) begin
                    chk(1'b0, "R8/R13", "unexpected result", {30'd0, rd_we, exc_valid}, 0);
                end else begin
                    e = sbq.pop_front();
                    if (e.exc) begin
                        chk(exc_valid && !rd_we, e.req, "exception without rd write",
                            {30'd0, exc_valid, rd_we}, 32'h2);
                        chk(exc_cause == e.cause, e.req, "cause", exc_cause, e.cause);
                    end else begin
                        chk(rd_we && !exc_valid, e.req, "rd write without exception",
                            {30'd0, rd_we, exc_valid}, 32'h2);
                        chk(rd_wdata == e.val, e.req, "rd value", rd_wdata, e.val);
                    end
                end
            end
        end
    end

    // One operation: address phase, optional stall, then completion
    task automatic bus_op(input logic [2:0] k, input bit fl, input int stall,
                          input bit err, input bit exok, input logic [31:0] rdat,
                          input bit exp_bus, input bit exp_excl,
                          input bit exp_res, input bit exp_exc,
                          input logic [3:0] exp_cause, input logic [31:0] exp_val,
                          input string req);
        @(negedge clk);
        op_kind = k; op_addr = 32'h0000_1230; flush = fl;
        hready = 1'b1; hresp_err = 1'b0; hexokay = 1'b0;
        #1;
        chk(htrans == (exp_bus ? TR_NONSEQ : TR_IDLE), req, "htrans", htrans,
            exp_bus ? TR_NONSEQ : TR_IDLE);
        chk(hexcl == exp_excl, req, "hexcl", hexcl, exp_excl);
        if (exp_res || exp_exc) push(exp_exc, exp_cause, exp_val, req);
        @(negedge clk);
        op_kind = OP_NONE; flush = 1'b0;
        for (int i = 0; i < stall; i++) begin
            hready = 1'b0;
            @(negedge clk);
        end
        hready = 1'b1; hresp_err = err; hexokay = exok; hrdata = rdat;
        @(negedge clk);
        hresp_err = 1'b0; hexokay = 1'b0; hrdata = '0;
        #3;
        chk(sbq.size() == 0, req, "result due in completion cycle", sbq.size(), 0);
        chk(!exc_valid, "R13", "exception pulse lasts one cycle", exc_valid, 0);
    endtask

    initial begin
        #(CLK_NS * 20000);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(htrans == TR_IDLE, "R1", "htrans in reset", htrans, TR_IDLE);
        chk(!rd_we && !exc_valid, "R1", "outputs in reset", {30'd0, rd_we, exc_valid}, 0);
        rst_n = 1'b1;

        // R1 / R5: first SC after reset is dropped, rd=0
        bus_op(OP_SC, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R1");
        bus_op(OP_SC, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R5");

        // R2 / R3: LR grants, SC succeeds, next SC dropped
        bus_op(OP_LR, 0, 0, 0, 1, 32'hA5A5_0001, 1, 1, 1, 0, 0, 32'hA5A5_0001, "R2");
        bus_op(OP_SC, 0, 0, 0, 1, 0, 1, 1, 1, 0, 0, 0, "R3");
        bus_op(OP_SC, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R3");

        // R2: LR without exclusive-okay leaves no reservation
        bus_op(OP_LR, 0, 0, 0, 0, 32'h0000_0042, 1, 1, 1, 0, 0, 32'h0000_0042, "R2");
        bus_op(OP_SC, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R2");

        // R4: SC without exclusive-okay writes 1, then dropped
        bus_op(OP_LR, 0, 0, 0, 1, 32'h11, 1, 1, 1, 0, 0, 32'h11, "R4");
        bus_op(OP_SC, 0, 0, 0, 0, 0, 1, 1, 1, 0, 0, 32'h1, "R4");
        bus_op(OP_SC, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R4");

        // R6: faulting LR with exclusive-okay stuck high
        bus_op(OP_LR, 0, 0, 0, 1, 32'h22, 1, 1, 1, 0, 0, 32'h22, "R6");
        bus_op(OP_LR, 0, 0, 1, 1, 32'h33, 1, 1, 0, 1, 4'd5, 0, "R6");
        bus_op(OP_SC, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R6");

        // R7: faulting SC, repeat dropped
        bus_op(OP_LR, 0, 0, 0, 1, 32'h44, 1, 1, 1, 0, 0, 32'h44, "R7");
        bus_op(OP_SC, 0, 0, 1, 1, 0, 1, 1, 0, 1, 4'd7, 0, "R7");
        bus_op(OP_SC, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R7");

        // R8: stalled LR and SC
        bus_op(OP_LR, 0, 3, 0, 1, 32'h55, 1, 1, 1, 0, 0, 32'h55, "R8");
        bus_op(OP_SC, 0, 2, 0, 1, 0, 1, 1, 1, 0, 0, 0, "R8");
        bus_op(OP_SC, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R8");

        // R9: atomic clears reservation; atomic error is cause 7
        bus_op(OP_LR, 0, 0, 0, 1, 32'h66, 1, 1, 1, 0, 0, 32'h66, "R9");
        bus_op(OP_AMO, 0, 0, 0, 0, 32'h77, 1, 0, 1, 0, 0, 32'h77, "R9");
        bus_op(OP_SC, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, "R9");
        bus_op(OP_AMO, 0, 0, 1, 0, 0, 1, 0, 0, 1, 4'd7, 0, "R9");

        // R10: ordinary loads and stores
        bus_op(OP_LOAD, 0, 0, 0, 0, 32'hDEAD_BEEF, 1, 0, 1, 0, 0, 32'hDEAD_BEEF, "R10");
        bus_op(OP_LOAD, 0, 1, 1, 0, 0, 1, 0, 0, 1, 4'd5, 0, "R10");
        bus_op(OP_STORE, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0, "R10");
        bus_op(OP_STORE, 0, 0, 1, 0, 0, 1, 0, 0, 1, 4'd7, 0, "R10");

        // R11: flushed atomic and flushed SC leave reservation alone
        bus_op(OP_LR, 0, 0, 0, 1, 32'h88, 1, 1, 1, 0, 0, 32'h88, "R11");
        bus_op(OP_AMO, 1, 0, 0, 0, 32'h99, 0, 0, 0, 0, 0, 0, "R11");
        bus_op(OP_SC, 1, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0, "R11");
        bus_op(OP_SC, 0, 0, 0, 1, 0, 1, 1, 1, 0, 0, 0, "R11");

        // R12: SC offered in the LR completion cycle
        @(negedge clk);
        op_kind = OP_LR; hready = 1'b1;
        #1;
        chk(htrans == TR_NONSEQ && hexcl, "R12", "LR request", {30'd0, htrans}, TR_NONSEQ);
        @(negedge clk);
        op_kind = OP_SC; hexokay = 1'b1; hrdata = 32'hCAFE_0012;
        push(0, 0, 32'hCAFE_0012, "R12");
        #1;
        chk(htrans == TR_NONSEQ, "R12", "SC issued on forwarded reservation", htrans, TR_NONSEQ);
        chk(hexcl && hwrite, "R12", "SC exclusive write", {30'd0, hexcl, hwrite}, 32'h3);
        push(0, 0, 0, "R12");
        @(negedge clk);
        op_kind = OP_NONE; hexokay = 1'b1; hrdata = '0;
        @(negedge clk);
        hexokay = 1'b0;
        #3;
        chk(sbq.size() == 0, "R12", "results drained", sbq.size(), 0);

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule